// File: doc/BRIEF.md
# Address-Range Cache Sync Sequencer

This block takes a byte region, given as a start address and a length, and walks it one cache line at a time. For every line it raises a single-line sync request, with the line address, on a downstream request/acknowledge port. It then waits for that port to accept the request before moving to the next line. The distance between lines comes from a step-size input, which is wired to a hardware parameter value such as the cache line size.

When the last line has been accepted, the sequencer raises a memory-ordering barrier request on a second request/acknowledge port. Once the barrier is acknowledged, it emits a one-cycle hazard-clear pulse that marks the region as synchronized. A zero length or a zero step size (no caches present) produces the hazard-clear pulse at once, with no requests at all.

An abort input ends a walk while a line request is pending. In that case no barrier is issued and an error pulse is raised. A counter of accepted line requests is brought out so that the walk can be observed.

Top module: `range_sync_seq`

## Requirements
- R1: After reset, `busy`, `line_req`, `bar_req`, `hz_clr` and `abort_err` are 0 and `line_count` is 0.
- R2: A command with `cmd_len` equal to 0, accepted while idle, gives `hz_clr`=1 for exactly one cycle in the cycle after `cmd_valid`. No line request and no barrier request is made, and `busy` stays 0.
- R3: A command with `step_bytes` equal to 0 and a nonzero length behaves as in R2: an immediate single-cycle `hz_clr`, with no requests.
- R4: A command with nonzero length and step, accepted while idle, raises `busy` and `line_req` in the cycle after `cmd_valid`, with `line_addr` equal to `cmd_start`.
- R5: A line request is transferred on a cycle in which `line_req` and `line_ack` are both 1 and `abort` is 0. The next line address is the current address plus `step_bytes`. Another request follows only while that sum is unsigned-less-than `cmd_start + cmd_len`. Both sums are formed one bit wider than the address, so they do not wrap, and `line_addr` carries the low address bits.
- R6: In the cycle after the last line transfer, `line_req` is 0 and `bar_req` is 1. In the cycle after `bar_req` and `bar_ack` are both 1, `hz_clr` is 1 for one cycle and `busy` is 0.
- R7: While `line_req` is 1 and neither `line_ack` nor `abort` is 1, the next cycle keeps `line_req` at 1 and `line_addr` unchanged. `bar_req` is likewise held until `bar_ack`.
- R8: `abort`=1 while `line_req`=1 ends the walk. In the next cycle `busy` is 0, `abort_err` is 1 for that one cycle, and no barrier is requested. An acknowledge in the same cycle is not counted. `abort` has no effect while no line request is pending.
- R9: `line_count` equals the number of line transfers since the last accepted command, and accepting a command clears it.
- R10: `cmd_valid` has no effect while `busy` is 1.
- R11: `line_req` and `bar_req` are never 1 together, and neither is 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a region walk (taken only while idle) |
| cmd_start | input | AW | First byte address of the region |
| cmd_len | input | AW | Region length in bytes |
| step_bytes | input | SW | Line step size; 0 means no caches |
| busy | output | 1 | A walk is in progress |
| line_req | output | 1 | Single-line sync request |
| line_addr | output | AW | Address of the requested line |
| line_ack | input | 1 | Line sync request accepted |
| bar_req | output | 1 | Memory-ordering barrier request |
| bar_ack | input | 1 | Barrier request accepted |
| abort | input | 1 | Abandon the walk while a line request is pending |
| hz_clr | output | 1 | One-cycle completion (hazard clear) pulse |
| abort_err | output | 1 | One-cycle pulse after an abort |
| line_count | output | CW | Line transfers since the last accepted command |

## Verification
A cursor that advances wrongly or has a stale end bound shows up on `line_addr` at the very next request, or as a barrier that comes one line early or late. Either way it appears within one cycle of the acknowledge concerned. A control state stuck or taking the wrong branch shows up on `busy`, `bar_req` or a missing `hz_clr` in the cycle after the command or the acknowledge. The walks are chosen so that the end falls exactly on a line boundary, one byte past it, one byte into a region, and across the top of the address space. This exposes off-by-one and wrap faults in the unsigned end compare through the number of line requests before the barrier.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINE = 2'd1,
    ST_BAR  = 2'd2
  } rss_state_t;
endpackage

// File: rtl/rss_cursor.sv
module rss_cursor #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] start,
  input  logic [AW-1:0] len,
  input  logic [SW-1:0] step,
  output logic [AW-1:0] cur_addr,
  output logic          more
);
  localparam int XW   = AW + 1;
  localparam int PADW = XW - SW;

  logic [XW-1:0] cur_q;
  logic [XW-1:0] end_q;
  logic [SW-1:0] step_q;
  logic [XW-1:0] nxt;

  assign nxt      = cur_q + {{PADW{1'b0}}, step_q};
  assign more     = nxt < end_q;
  assign cur_addr = cur_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      end_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      cur_q  <= {1'b0, start};
      end_q  <= {1'b0, start} + {1'b0, len};
      step_q <= step;
    end else if (adv) begin
      cur_q <= nxt;
    end
  end

  // R5
  adv_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && step_q != '0) |=> (cur_q > $past(cur_q)));
endmodule

// File: rtl/rss_counter.sv
module rss_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (count == $past(count) + 1'b1));
  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/rss_fsm.sv
module rss_fsm
  import rss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       zero_cmd,
  input  logic       line_ack,
  input  logic       bar_ack,
  input  logic       abort,
  input  logic       more,
  output rss_state_t state,
  output logic       load,
  output logic       adv,
  output logic       clr,
  output logic       hz_clr,
  output logic       abort_err
);
  logic idle;
  assign idle = (state == ST_IDLE);
  assign clr  = idle && cmd_valid;
  assign load = idle && cmd_valid && !zero_cmd;
  assign adv  = (state == ST_LINE) && line_ack && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hz_clr    <= 1'b0;
      abort_err <= 1'b0;
    end else begin
      hz_clr    <= 1'b0;
      abort_err <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          if (zero_cmd) hz_clr <= 1'b1;
          else          state  <= ST_LINE;
        end
        ST_LINE: begin
          if (abort) begin
            state     <= ST_IDLE;
            abort_err <= 1'b1;
          end else if (line_ack && !more) begin
            state <= ST_BAR;
          end
        end
        ST_BAR: if (bar_ack) begin
          state  <= ST_IDLE;
          hz_clr <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  hz_single_chk: assert property (@(posedge clk) disable iff (rst)
    hz_clr |=> !hz_clr);
  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_err |=> !abort_err);
  // R8
  abort_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LINE && abort) |=> (state == ST_IDLE && abort_err && !hz_clr));
endmodule

// File: rtl/range_sync_seq.sv
module range_sync_seq
  import rss_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_start,
  input  logic [AW-1:0] cmd_len,
  input  logic [SW-1:0] step_bytes,
  output logic          busy,
  output logic          line_req,
  output logic [AW-1:0] line_addr,
  input  logic          line_ack,
  output logic          bar_req,
  input  logic          bar_ack,
  input  logic          abort,
  output logic          hz_clr,
  output logic          abort_err,
  output logic [CW-1:0] line_count
);
  rss_state_t state;
  logic load, adv, clr, more, zero_cmd;

  assign zero_cmd = (cmd_len == '0) || (step_bytes == '0);

  rss_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .zero_cmd(zero_cmd),
    .line_ack(line_ack), .bar_ack(bar_ack), .abort(abort), .more(more),
    .state(state), .load(load), .adv(adv), .clr(clr),
    .hz_clr(hz_clr), .abort_err(abort_err)
  );

  rss_cursor #(.AW(AW), .SW(SW)) u_cursor (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .start(cmd_start), .len(cmd_len), .step(step_bytes),
    .cur_addr(line_addr), .more(more)
  );

  rss_counter #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .clr(clr), .inc(adv), .count(line_count)
  );

  assign busy     = (state != ST_IDLE);
  assign line_req = (state == ST_LINE);
  assign bar_req  = (state == ST_BAR);

  // R11
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_req && bar_req));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!line_req && !bar_req));
  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_req && !line_ack && !abort) |=> (line_req && $stable(line_addr)));
  // R7
  bar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bar_req && !bar_ack) |=> bar_req);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (line_req && cmd_valid && !line_ack && !abort) |=> $stable(line_addr));
endmodule

// File: tb/range_sync_seq_bench.sv
module range_sync_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [AW-1:0] cmd_start = '0;
  logic [AW-1:0] cmd_len = '0;
  logic [SW-1:0] step_bytes = '0;
  logic line_ack = 1'b0, bar_ack = 1'b0, abort = 1'b0;
  logic busy, line_req, bar_req, hz_clr, abort_err;
  logic [AW-1:0] line_addr;
  logic [CW-1:0] line_count;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_sync_seq #(.AW(AW), .SW(SW), .CW(CW)) u_range_sync_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_len(cmd_len), .step_bytes(step_bytes), .busy(busy),
    .line_req(line_req), .line_addr(line_addr), .line_ack(line_ack),
    .bar_req(bar_req), .bar_ack(bar_ack), .abort(abort),
    .hz_clr(hz_clr), .abort_err(abort_err), .line_count(line_count)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] s, input logic [AW-1:0] l, input logic [SW-1:0] st);
    cmd_start = s; cmd_len = l; step_bytes = st; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Walk with immediate acks; checks every address, barrier and completion.
  task automatic walk(input logic [AW-1:0] s, input logic [AW-1:0] l,
                      input logic [SW-1:0] st, input int nlines, input string tag);
    logic [AW:0] exp_a;
    int ok_addr;
    exp_a = {1'b0, s};
    ok_addr = 1;
    issue(s, l, st);
    chk(busy && line_req, {tag, " R4 start"}, {busy, line_req}, 2'b11);
    chk(line_addr == s, {tag, " R4 first addr"}, line_addr, s);
    for (int i = 0; i < nlines; i++) begin
      if (!(line_req && line_addr == exp_a[AW-1:0])) begin
        ok_addr = 0;
        $display("FAIL %s R5 line %0d actual=%0h expected=%0h", tag, i, line_addr, exp_a[AW-1:0]);
      end
      line_ack = 1'b1;
      @(negedge clk);
      line_ack = 1'b0;
      exp_a = exp_a + {{(AW+1-SW){1'b0}}, st};
    end
    chk(ok_addr == 1, {tag, " R5 addresses"}, ok_addr, 1);
    chk(bar_req && !line_req, {tag, " R6 barrier after last"}, {bar_req, line_req}, 2'b10);
    chk(line_count == CW'(nlines), {tag, " R9 count"}, line_count, nlines);
    @(negedge clk);
    chk(bar_req && !hz_clr, {tag, " R7 barrier held"}, {bar_req, hz_clr}, 2'b10);
    bar_ack = 1'b1;
    @(negedge clk);
    bar_ack = 1'b0;
    chk(hz_clr && !busy, {tag, " R6 done"}, {hz_clr, busy}, 2'b10);
    @(negedge clk);
    chk(!hz_clr, {tag, " R6 single pulse"}, hz_clr, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !line_req && !bar_req && !hz_clr && !abort_err, "R1 outputs",
        {busy, line_req, bar_req, hz_clr, abort_err}, 0);
    chk(line_count == 0, "R1 count", line_count, 0);
  endtask

  task automatic t_zero(input logic [AW-1:0] l, input logic [SW-1:0] st, input string req);
    issue(32'h200, l, st);
    chk(hz_clr && !busy && !line_req && !bar_req, {req, " immediate done"},
        {hz_clr, busy, line_req, bar_req}, 4'b1000);
    chk(line_count == 0, {req, " count zero"}, line_count, 0);
    @(negedge clk);
    chk(!hz_clr && !busy, {req, " pulse ends"}, {hz_clr, busy}, 0);
  endtask

  task automatic t_stall_busy();
    issue(32'h1000, 32'h20, 16'h10);
    abort = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_req && line_addr == 32'h1000, "R7 stall held", line_addr, 32'h1000);
    cmd_start = 32'h5000; cmd_len = 32'h0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(line_req && line_addr == 32'h1000 && !hz_clr, "R10 cmd ignored", line_addr, 32'h1000);
    line_ack = 1'b1; @(negedge clk);
    line_ack = 1'b0;
    chk(line_addr == 32'h1010, "R5 stalled advance", line_addr, 32'h1010);
    line_ack = 1'b1; @(negedge clk);
    line_ack = 1'b0;
    abort = 1'b1; @(negedge clk);
    abort = 1'b0;
    chk(bar_req && !abort_err, "R8 abort ignored in barrier", {bar_req, abort_err}, 2'b10);
    bar_ack = 1'b1; @(negedge clk);
    bar_ack = 1'b0;
    chk(hz_clr && line_count == 2, "R6 stalled done", line_count, 2);
    @(negedge clk);
  endtask

  task automatic t_abort();
    issue(32'h3000, 32'h100, 16'h20);
    line_ack = 1'b1; @(negedge clk);
    chk(line_addr == 32'h3020, "R5 second line", line_addr, 32'h3020);
    abort = 1'b1;
    @(negedge clk);
    line_ack = 1'b0; abort = 1'b0;
    chk(abort_err && !busy && !bar_req && !line_req, "R8 abort ends",
        {abort_err, busy, bar_req, line_req}, 4'b1000);
    chk(line_count == 1, "R8 ack not counted", line_count, 1);
    @(negedge clk);
    chk(!abort_err && !hz_clr && !bar_req, "R8 no barrier, pulse ends",
        {abort_err, hz_clr, bar_req}, 0);
    abort = 1'b1; @(negedge clk);
    abort = 1'b0;
    chk(!abort_err, "R8 idle abort no effect", abort_err, 0);
    issue(32'h0, 32'h0, 16'h10);
    chk(line_count == 0, "R9 cleared on accept", line_count, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero(32'h0, 16'h10, "R2");
    t_zero(32'h80, 16'h0, "R3");
    walk(32'h100, 32'h40, 16'h10, 4, "aligned");
    walk(32'h100, 32'h41, 16'h10, 5, "one past");
    walk(32'h107, 32'h1, 16'h40, 1, "single byte");
    walk(32'hFFFF_FFF0, 32'h20, 16'h10, 2, "top wrap");
    t_stall_busy();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule